// File: doc/BRIEF.md
# Enable-Timed Fast-to-Slow Word Bridge

This block carries data words between a fast bus clock domain and a slow logic section. The slow section does not have its own clock: it runs on the same fast clock and updates only when a periodic enable pulse, generated here by dividing the fast clock, is high. Because both sides share one clock, no asynchronous FIFO or synchronizer is needed. Instead, each transfer is placed at a known phase of the slow period.

On the fast side, a valid/ready write port feeds a small buffer. A bus write completes at once whenever the buffer has room, so the bus is never held for a slow period. One cycle before each slow enable pulse, the next buffered word moves into a staging register. That register drives the slow section and stays constant across the update. If the buffer is empty at that point, the staging register keeps its previous word and a no-new-data flag is raised for that slow period.

In the other direction, the slow section's result is sampled exactly once per slow period, one fast cycle after the update. It is then presented to the fast side with a one-cycle valid pulse.

Top module: `slow_xfer_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_ready` is 1, and `slow_tick`, `slow_nodata`, `ret_valid`, `slow_data` and `ret_data` are all 0.
- R2: `slow_tick` is high for exactly one cycle in every DIV cycles. Counting the first cycle after reset release as cycle 0, the first pulse is in cycle DIV-1.
- R3: The buffer holds up to DEPTH words. `wr_ready` is 0 while it is full. A write offered while `wr_ready` is 0 is dropped and never appears on `slow_data`.
- R4: Accepted words appear on `slow_data` in the order they were written, one per slow period.
- R5: `slow_data` changes only on the clock edge that begins a `slow_tick` cycle. That is one fast clock before the edge at which the slow section updates.
- R6: `slow_data` holds the same value during the `slow_tick` cycle and the cycle after it.
- R7: If the buffer is empty one cycle before a slow tick, `slow_data` keeps its previous value and `slow_nodata` is 1 during that tick. If a new word is delivered, `slow_nodata` is 0.
- R8: `ret_valid` is high for exactly one cycle, two cycles after each `slow_tick` cycle, and at no other time.
- R9: While `ret_valid` is high, `ret_data` equals the value `ret_data_in` had in the cycle after the `slow_tick`. `ret_data` does not change while `ret_valid` is low.
- R10: When the buffer is not full, `wr_ready` is 1 at every phase of the slow period, including tick and pre-tick cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus offers a word |
| wr_ready | output | 1 | Buffer can accept a word this cycle |
| wr_data | input | DW | Word offered by the bus |
| slow_tick | output | 1 | One-cycle enable for the slow section |
| slow_data | output | DW | Staged word presented to the slow section |
| slow_nodata | output | 1 | No new word was staged for this slow period |
| ret_data_in | input | DW | Result register of the slow section |
| ret_valid | output | 1 | One-cycle pulse marking a fresh returned word |
| ret_data | output | DW | Returned word captured in the fast domain |

## Verification
The bench builds the block with DIV=8, DEPTH=4 and DW=16. With a short slow period, many complete periods fit in a short run. It also lets the bench fill the four-entry buffer between two ticks, so that a write offered while `wr_ready` is low can be tested. Because the buffer can be drained within a few periods, the empty-buffer hold and its flag can be reached as well. The small divider also makes it possible to place single writes on the tick and pre-tick cycles.

// File: rtl/slowx_pkg.sv
// Package: shared types for the enable-timed bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package slowx_pkg;

    // Phase markers of the slow period, all one fast cycle wide
    typedef struct packed {
        logic pre;   // cycle before the slow tick: staging slot
        logic tick;  // slow-section update enable
        logic cap;   // cycle after the tick: return sample slot
    } slowx_phase_t;

endpackage

// File: rtl/slowx_tick_gen.sv
// Module: slow period generator.
// Divides the fast clock by DIV and marks the pre-tick, tick and capture
// cycles of each slow period.
// Assumes: DIV >= 3, so the three phase cycles never coincide.
module slowx_tick_gen #(
    parameter int DIV = 500000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output slowx_pkg::slowx_phase_t phase
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] PRE  = CW'(DIV - 2);

    logic [CW-1:0] cnt_q;
    logic          cap_q;

    // Period counter: wraps to zero after the tick cycle
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // Capture marker: one cycle after the tick
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= (cnt_q == LAST);
    end

    // Phase decode from the counter state
    always_comb begin
        phase.pre  = (cnt_q == PRE);
        phase.tick = (cnt_q == LAST);
        phase.cap  = cap_q;
    end
endmodule

// File: rtl/slowx_buf.sv
// Module: small synchronous word buffer (first in, first out).
// Assumes: DEPTH is a power of two, >= 2; push is never requested while full.
module slowx_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW:0]   count_q;
    logic [DW-1:0] slot_q [DEPTH];

    // One storage register per entry, written when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr_q == AW'(i))) slot_q[i] <= push_data;
        end
    end

    // Write pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr_q <= '0;
        else if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
    end

    // Read pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_ptr_q <= '0;
        else if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
    end

    // Occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else begin
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Status and head word
    always_comb begin
        full  = (count_q == CAP);
        empty = (count_q == '0);
        head  = slot_q[rd_ptr_q];
    end
endmodule

// File: rtl/slowx_stage.sv
// Module: staging register for the slow side.
// At the pre-tick slot it takes the buffer head when one is present and
// otherwise keeps its word and raises the no-new-data flag.
// Assumes: load_slot pulses one cycle before the slow tick.
module slowx_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_slot,
    input  logic          have_word,
    input  logic [DW-1:0] word_in,
    output logic          take,
    output logic [DW-1:0] stage_q,
    output logic          nodata_q
);
    // Pop request toward the buffer
    always_comb take = load_slot && have_word;

    // Staged word: updated only at the staging slot
    always_ff @(posedge clk) begin
        if (!rst_n)    stage_q <= '0;
        else if (take) stage_q <= word_in;
    end

    // No-new-data flag: refreshed at each staging slot
    always_ff @(posedge clk) begin
        if (!rst_n)         nodata_q <= 1'b0;
        else if (load_slot) nodata_q <= !have_word;
    end
endmodule

// File: rtl/slowx_ret_cap.sv
// Module: single capture of the slow section's result into the fast side.
// Assumes: cap pulses once per slow period, after the slow update.
module slowx_ret_cap #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] ret_in,
    output logic          valid_q,
    output logic [DW-1:0] data_q
);
    // Held return word: loaded once per slow period
    always_ff @(posedge clk) begin
        if (!rst_n)   data_q <= '0;
        else if (cap) data_q <= ret_in;
    end

    // One-cycle valid pulse following the capture
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= cap;
    end
endmodule

// File: rtl/slow_xfer_bridge.sv
// Module: top of the enable-timed bridge between a fast bus and slow logic.
// Writes land in a small buffer; one word is staged before each slow tick
// and the slow result is captured once after it.
// Assumes: slow logic is clocked by clk and updates only when slow_tick is 1;
// DIV >= 3; DEPTH is a power of two.
module slow_xfer_bridge #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int DIV   = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic          slow_tick,
    output logic [DW-1:0] slow_data,
    output logic          slow_nodata,
    input  logic [DW-1:0] ret_data_in,
    output logic          ret_valid,
    output logic [DW-1:0] ret_data
);
    slowx_pkg::slowx_phase_t phase;
    logic          buf_full, buf_empty, take, push;
    logic [DW-1:0] head;

    slowx_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    // Bus handshake: accept whenever there is room
    always_comb begin
        wr_ready = !buf_full;
        push     = wr_valid && !buf_full;
    end

    slowx_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (take),
        .head      (head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    slowx_stage #(.DW(DW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_slot (phase.pre),
        .have_word (!buf_empty),
        .word_in   (head),
        .take      (take),
        .stage_q   (slow_data),
        .nodata_q  (slow_nodata)
    );

    slowx_ret_cap #(.DW(DW)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (phase.cap),
        .ret_in  (ret_data_in),
        .valid_q (ret_valid),
        .data_q  (ret_data)
    );

    // Slow-section enable
    always_comb slow_tick = phase.tick;
endmodule

// File: rtl/slowx_bridge_chk.sv
// Module: property checker for slow_xfer_bridge, attached by bind.
// Assumes: observes top-level ports only; keeps its own period counter.
module slowx_bridge_chk #(
    parameter int DW  = 32,
    parameter int DIV = 500000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_ready,
    input logic          slow_tick,
    input logic [DW-1:0] slow_data,
    input logic          slow_nodata,
    input logic [DW-1:0] ret_data_in,
    input logic          ret_valid,
    input logic [DW-1:0] ret_data
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] gap_q;

    // Cycles since reset or since the last tick
    always_ff @(posedge clk) begin
        if (!rst_n)         gap_q <= '0;
        else if (slow_tick) gap_q <= '0;
        else                gap_q <= gap_q + 1'b1;
    end

    // R2
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> (gap_q == LAST));
    // R2
    tick_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == LAST) |-> slow_tick);
    // R5
    stage_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow_data) |-> slow_tick);
    // R6
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> $stable(slow_data));
    // R7
    nodata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && slow_nodata) |-> $stable(slow_data));
    // R8
    ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> ##1 ret_valid);
    // R8
    ret_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(slow_tick, 2));
    // R9
    ret_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> ##1 (ret_data == $past(ret_data_in)));
    // R9
    ret_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |-> $stable(ret_data));
    // R1
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> (wr_ready && !ret_valid && !slow_tick));
endmodule

bind slow_xfer_bridge slowx_bridge_chk #(.DW(DW), .DIV(DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ready    (wr_ready),
    .slow_tick   (slow_tick),
    .slow_data   (slow_data),
    .slow_nodata (slow_nodata),
    .ret_data_in (ret_data_in),
    .ret_valid   (ret_valid),
    .ret_data    (ret_data)
);

// File: tb/sim_slow_xfer_bridge.sv
module sim_slow_xfer_bridge;
    localparam int DW = 16, DEPTH = 4, DIV = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, slow_tick, slow_nodata, ret_valid;
    logic [DW-1:0] slow_data, ret_data, ret_data_in;
    logic [DW-1:0] slow_reg;

    int n_cmp = 0, n_bad = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] ret_q[$];
    bit   run_done = 0;
    bit   mon_on = 0;
    int   nodata_seen = 0;

    always #10 clk = ~clk;   // 50 MHz

    slow_xfer_bridge #(.DW(DW), .DEPTH(DEPTH), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .slow_tick(slow_tick), .slow_data(slow_data),
        .slow_nodata(slow_nodata), .ret_data_in(ret_data_in),
        .ret_valid(ret_valid), .ret_data(ret_data)
    );

    // Slow-section model: updates only on the enable
    always @(posedge clk) begin
        if (!rst_n)         slow_reg <= '0;
        else if (slow_tick) slow_reg <= slow_data * 16'd3 + 16'd1;
    end
    assign ret_data_in = slow_reg;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Driver: one-cycle write attempt, pushes expectation if accepted
    task automatic try_write(input logic [DW-1:0] d, output bit acc);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        acc = wr_ready;
        if (acc) exp_q.push_back(d);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!slow_tick);
    endtask

    // Monitor: scoreboard on the staged and returned words
    int  cyc = 0, last_tick = -1;
    logic [1:0] th = 2'b00;
    logic [DW-1:0] last_stage = '0, tick_stage = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            // R2 period and first position
            if (slow_tick) begin
                if (last_tick < 0) check(cyc == DIV - 1, "R2 first", cyc, DIV - 1);
                else               check(cyc - last_tick == DIV, "R2 period",
                                         cyc - last_tick, DIV);
                last_tick = cyc;
                if (!slow_nodata) begin
                    if (exp_q.size() == 0) check(0, "R4 unexpected word", slow_data, 0);
                    else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        check(slow_data == e, "R4 order", slow_data, e);
                    end
                end else begin
                    nodata_seen++;
                    check(slow_data == last_stage, "R7 hold", slow_data, last_stage);
                end
                tick_stage = slow_data;
            end else if (!th[0]) begin
                check(slow_data == last_stage, "R5 change only at tick", slow_data, last_stage);
            end
            // R6 stable in the cycle after the tick
            if (th[0]) check(slow_data == tick_stage, "R6 hold", slow_data, tick_stage);
            // R8 timing of the return pulse
            check(ret_valid == th[1], "R8 pulse", ret_valid, th[1]);
            if (th[0]) ret_q.push_back(ret_data_in);
            if (ret_valid) begin
                if (ret_q.size() == 0) check(0, "R9 no expected return", ret_data, 0);
                else begin
                    logic [DW-1:0] r;
                    r = ret_q.pop_front();
                    check(ret_data == r, "R9 value", ret_data, r);
                end
            end
            last_stage = slow_data;
            th  = {th[0], slow_tick};
            cyc++;
        end
    end

    initial begin
        bit acc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
        check({slow_tick, slow_nodata, ret_valid} == 3'b000, "R1 flags",
              {slow_tick, slow_nodata, ret_valid}, 0);
        check(slow_data == '0 && ret_data == '0, "R1 data", slow_data, 0);
        rst_n = 1'b1;
        mon_on = 1;
        check(wr_ready == 1'b1 && slow_tick == 1'b0, "R1 first cycle", wr_ready, 1);

        // Fill the buffer right after a tick
        wait_tick();
        for (int i = 0; i < DEPTH; i++) begin
            wr_valid = 1'b1; wr_data = DW'(16'h1000 + i);
            check(wr_ready == 1'b1, "R10 room", wr_ready, 1);
            exp_q.push_back(wr_data);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        // R3 full: write must be refused and dropped
        check(wr_ready == 1'b0, "R3 full", wr_ready, 0);
        try_write(16'hDEAD, acc);
        check(acc == 1'b0, "R3 refused", acc, 0);

        // Drain everything, then observe empty ticks
        repeat (DEPTH + 2) wait_tick();
        check(nodata_seen >= 1, "R7 flag raised", nodata_seen, 1);
        check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);

        // Single writes at every phase of the period (R10)
        for (int p = 0; p < DIV; p++) begin
            wait_tick();
            repeat (p) @(negedge clk);
            try_write(DW'(16'h2000 + p), acc);
            check(acc == 1'b1, "R10 any phase", acc, 1);
        end
        repeat (DIV + 2) wait_tick();
        check(exp_q.size() == 0, "R4 all delivered", exp_q.size(), 0);

        // Back-to-back stream longer than the buffer
        for (int i = 0; i < 12; i++) begin
            do try_write(DW'(16'h3000 + i), acc); while (!acc);
        end
        repeat (DEPTH + 3) wait_tick();
        check(exp_q.size() == 0, "R4 stream delivered", exp_q.size(), 0);
        check(slow_nodata == 1'b1, "R7 idle flag", slow_nodata, 1);

        run_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!run_done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule